// File: doc/BRIEF.md
# Oversampling Serial Character Receiver with Error Tags

This block turns an asynchronous serial line into character entries for a UART. A 16x enable tick paces it. The line is first brought into the clock domain through a short synchronizer. The receiver then waits for a falling edge and confirms the start bit half a bit period later. After that it takes one mid-bit sample for each data bit, for the optional parity bit and for the stop bit.

Each finished character becomes an 11-bit entry: eight data bits plus three tags for break, framing error and parity error. The entry goes to a downstream store, which is either a single holding register or a queue. A `sink_full` input reports whether that store still holds unread data. In holding-register mode a new character overwrites the unread one. In queued mode a full store turns the new character away. In both cases the receiver raises an overrun pulse.

Top module: `uart_rx_tagger`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `ent_valid` and `overrun` are 0 and `ent_word` is 0.
- R2: A start is armed only by a tick that sees the synchronized line low after the previous tick saw it high. The start is accepted only if the line is still low on the 8th tick after that; otherwise no entry is produced and the receiver hunts again.
- R3: Data bits arrive LSB first. Each one is sampled 16 ticks after the previous sample, and the sampled value lands in `ent_word[7:0]`.
- R4: `word_len` selects 5, 6, 7 or 8 data bits (codes 0, 1, 2, 3). Entry data bits at and above the word length are 0.
- R5: When `par_en` is 1, one parity bit follows the data. With `par_even`=1 the data ones plus the parity bit must be even; with `par_even`=0 they must be odd. A mismatch sets `ent_word[8]`. When `par_en` is 0, no parity bit is taken and `ent_word[8]` is 0.
- R6: A stop-bit sample of 0 sets the framing tag `ent_word[9]`.
- R7: A character whose data samples, parity sample (if any) and stop sample are all 0 is a break. Its entry has `ent_word[10]`=1, `ent_word[9]`=1, `ent_word[8]`=0 and data 0. The receiver then waits for the line to go high before it hunts again.
- R8: `ent_valid` is a one-cycle pulse. It is asserted in the clock after the tick that samples the stop bit, and `ent_word` holds the entry from then until the next entry.
- R9: With `queue_mode`=0 and `sink_full`=1 at the stop sample, the entry is still delivered, and `overrun` pulses in the same cycle as `ent_valid`.
- R10: With `queue_mode`=1 and `sink_full`=1 at the stop sample, no `ent_valid` is raised, `ent_word` keeps its previous value and `overrun` pulses.
- R11: After a character ends with the line still low (a framing error without a break), no new character starts until the line has gone high and then falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| tick16 | input | 1 | One-cycle enable at 16 times the bit rate |
| word_len | input | 2 | Data bits: 0=5, 1=6, 2=7, 3=8 |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| queue_mode | input | 1 | 0 = holding register downstream, 1 = queue downstream |
| sink_full | input | 1 | Downstream store holds unread data or is full |
| ent_word | output | 11 | Entry: [10] break, [9] framing, [8] parity error, [7:0] data |
| ent_valid | output | 1 | One-cycle strobe for a new entry |
| overrun | output | 1 | One-cycle pulse when a character arrives while the store is full |

## Verification
The cycles that matter most are those where a completed stop-bit sample coincides with `sink_full`. In those cycles, delivering an entry and reporting overrun land together, and the mode decides whether the entry overwrites the store or is dropped. The bench holds `sink_full` high across whole characters in each mode. A behavioural model then decides the expected valid, word and overrun for every clock, and the bench also checks the captured word and the pulse counts afterwards. A break also makes the framing and break tags coincide in one entry, and that case is judged the same way.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int DATA_BITS = 8;
  localparam int MIN_BITS  = 5;
  localparam int ENTRY_W   = DATA_BITS + 3;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_BRKW
  } rx_state_t;

  typedef struct packed {
    logic                 brk;
    logic                 frm;
    logic                 par;
    logic [DATA_BITS-1:0] data;
  } rx_entry_t;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= 1'b1;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_s,
  input  logic       tick,
  input  logic [1:0] word_len,
  input  logic       par_en,
  input  logic       par_even,
  output logic       done,
  output rx_entry_t  entry
);
  localparam int CNT_W = $clog2(OSR);
  localparam int MID   = OSR / 2;
  localparam int IDX_W = $clog2(DATA_BITS);

  rx_state_t            state;
  logic [CNT_W-1:0]     cnt;
  logic [IDX_W-1:0]     idx;
  logic [IDX_W-1:0]     last_idx;
  logic [DATA_BITS-1:0] shreg;
  logic                 par_acc, par_bit, all_low, last_lvl;
  logic                 samp, brk_now;

  assign last_idx = IDX_W'(MIN_BITS - 1) + IDX_W'(word_len);

  always_comb begin
    case (state)
      ST_START:                samp = tick && (cnt == CNT_W'(MID - 1));
      ST_DATA, ST_PAR, ST_STOP: samp = tick && (cnt == CNT_W'(OSR - 1));
      default:                 samp = 1'b0;
    endcase
  end

  assign done       = samp && (state == ST_STOP);
  assign brk_now    = all_low && !rx_s;
  assign entry.brk  = brk_now;
  assign entry.frm  = !rx_s;
  assign entry.par  = par_en && !brk_now && (par_acc ^ par_bit ^ !par_even);
  assign entry.data = shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_HUNT;
      cnt      <= '0;
      idx      <= '0;
      shreg    <= '0;
      par_acc  <= 1'b0;
      par_bit  <= 1'b0;
      all_low  <= 1'b0;
      last_lvl <= 1'b1;
    end else if (tick) begin
      last_lvl <= rx_s;
      if (state != ST_HUNT && state != ST_BRKW)
        cnt <= samp ? '0 : cnt + 1'b1;
      case (state)
        ST_HUNT: begin
          if (last_lvl && !rx_s) begin
            state <= ST_START;
            cnt   <= '0;
          end
        end
        ST_START: begin
          if (samp) begin
            if (!rx_s) begin
              state   <= ST_DATA;
              idx     <= '0;
              shreg   <= '0;
              par_acc <= 1'b0;
              all_low <= 1'b1;
            end else begin
              state <= ST_HUNT;
            end
          end
        end
        ST_DATA: begin
          if (samp) begin
            shreg[idx] <= rx_s;
            par_acc    <= par_acc ^ rx_s;
            all_low    <= all_low & !rx_s;
            if (idx == last_idx) state <= par_en ? ST_PAR : ST_STOP;
            else                 idx   <= idx + 1'b1;
          end
        end
        ST_PAR: begin
          if (samp) begin
            par_bit <= rx_s;
            all_low <= all_low & !rx_s;
            state   <= ST_STOP;
          end
        end
        ST_STOP: begin
          if (samp) state <= brk_now ? ST_BRKW : ST_HUNT;
        end
        ST_BRKW: begin
          if (rx_s) state <= ST_HUNT;
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

  // R2: data phase is entered only from a tick that saw the line low
  p_start_mid_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DATA && $past(state) == ST_START) |-> ($past(tick) && !$past(rx_s)));

  // R7: leaving the break wait requires a high line
  p_brk_wait_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HUNT && $past(state) == ST_BRKW) |-> $past(rx_s));
endmodule

// File: rtl/rx_handoff.sv
module rx_handoff
  import uart_rx_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               done,
  input  rx_entry_t          entry,
  input  logic               queue_mode,
  input  logic               sink_full,
  output logic [ENTRY_W-1:0] ent_word,
  output logic               ent_valid,
  output logic               overrun
);
  logic accept;
  assign accept = done && !(queue_mode && sink_full);

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_word  <= '0;
      ent_valid <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      ent_valid <= accept;
      overrun   <= done && sink_full;
      if (accept) ent_word <= entry;
    end
  end

  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    ent_valid |=> !ent_valid);

  p_hold_write_r9: assert property (@(posedge clk) disable iff (rst)
    (done && !queue_mode && sink_full) |=> (ent_valid && overrun));

  p_queue_drop_r10: assert property (@(posedge clk) disable iff (rst)
    (done && queue_mode && sink_full) |=> (!ent_valid && overrun && $stable(ent_word)));

  p_break_tags_r7: assert property (@(posedge clk) disable iff (rst)
    (ent_valid && ent_word[ENTRY_W-1]) |-> (ent_word[ENTRY_W-2] && ent_word[DATA_BITS-1:0] == '0));
endmodule

// File: rtl/uart_rx_tagger.sv
module uart_rx_tagger
  import uart_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rx_in,
  input  logic        tick16,
  input  logic [1:0]  word_len,
  input  logic        par_en,
  input  logic        par_even,
  input  logic        queue_mode,
  input  logic        sink_full,
  output logic [10:0] ent_word,
  output logic        ent_valid,
  output logic        overrun
);
  logic      rx_s;
  logic      done;
  rx_entry_t entry;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (rx_in),
    .q   (rx_s)
  );

  rx_frame_fsm #(.OSR(OSR)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .rx_s     (rx_s),
    .tick     (tick16),
    .word_len (word_len),
    .par_en   (par_en),
    .par_even (par_even),
    .done     (done),
    .entry    (entry)
  );

  rx_handoff u_hand (
    .clk        (clk),
    .rst        (rst),
    .done       (done),
    .entry      (entry),
    .queue_mode (queue_mode),
    .sink_full  (sink_full),
    .ent_word   (ent_word),
    .ent_valid  (ent_valid),
    .overrun    (overrun)
  );

  // R4: bits above the word length of the latched character are zero
  p_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
    ent_valid |-> ((ent_word[7:0] >> ({2'b00, $past(word_len)} + 4'd5)) == 8'd0));
endmodule

// File: tb/uart_rx_tagger_tb.sv
module uart_rx_tagger_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV       = 3;
  localparam int BITCLK     = 16 * TDIV;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_in = 1'b1;
  logic        tick16 = 1'b0;
  logic [1:0]  word_len = 2'd3;
  logic        par_en = 1'b0;
  logic        par_even = 1'b0;
  logic        queue_mode = 1'b0;
  logic        sink_full = 1'b0;
  logic [10:0] ent_word;
  logic        ent_valid;
  logic        overrun;

  int    n_chk = 0;
  int    n_bad = 0;
  string cur_req = "R1";

  uart_rx_tagger u_dut (
    .clk(clk), .rst(rst), .rx_in(rx_in), .tick16(tick16), .word_len(word_len),
    .par_en(par_en), .par_even(par_even), .queue_mode(queue_mode),
    .sink_full(sink_full), .ent_word(ent_word), .ent_valid(ent_valid), .overrun(overrun)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    int tc;
    tc = 0;
    forever begin
      @(negedge clk);
      tick16 = (tc == 0);
      tc = (tc + 1) % TDIV;
    end
  end

  // Behavioural reference: ticks counted since the start edge
  logic [10:0] m_word;
  logic        m_valid, m_ovr;
  int m_s1, m_s2, phase, tk, prev, dat, ones, pb, lows;

  always @(posedge clk) begin
    int lvl, k, nb, stopk, brk, frm, perr;
    if (rst) begin
      m_s1 = 1; m_s2 = 1; phase = 0; prev = 1; tk = 0;
      m_word = '0; m_valid = 1'b0; m_ovr = 1'b0;
    end else begin
      lvl = m_s2; m_s2 = m_s1; m_s1 = int'(rx_in);
      m_valid = 1'b0; m_ovr = 1'b0;
      if (tick16) begin
        if (phase == 0) begin
          if (prev == 1 && lvl == 0) begin phase = 1; tk = 0; end
        end else if (phase == 2) begin
          if (lvl == 1) phase = 0;
        end else begin
          tk++;
          if (tk % 16 == 8) begin
            k = (tk - 8) / 16;
            nb = 5 + int'(word_len);
            stopk = nb + 1 + (par_en ? 1 : 0);
            if (k == 0) begin
              if (lvl == 1) phase = 0;
              else begin dat = 0; ones = 0; lows = 1; pb = 0; end
            end else if (k <= nb) begin
              dat = dat + (lvl << (k - 1)); ones += lvl; if (lvl == 1) lows = 0;
            end else if (k == stopk) begin
              brk  = (lows == 1 && lvl == 0) ? 1 : 0;
              frm  = (lvl == 0) ? 1 : 0;
              perr = (par_en && brk == 0 && ((ones + pb) % 2) != (par_even ? 0 : 1)) ? 1 : 0;
              if (queue_mode && sink_full) m_ovr = 1'b1;
              else begin
                m_valid = 1'b1; m_ovr = sink_full;
                m_word = 11'((brk << 10) + (frm << 9) + (perr << 8) + dat);
              end
              phase = (brk == 1) ? 2 : 0;
            end else begin
              pb = lvl; if (lvl == 1) lows = 0;
            end
          end
        end
        prev = lvl;
      end
    end
  end

  int          got = 0, ovr_cnt = 0, run = 0, max_run = 0;
  logic [10:0] last_word = '0;

  always @(negedge clk) begin
    if (!rst) begin
      n_chk++;
      if (ent_valid !== m_valid || ent_word !== m_word || overrun !== m_ovr) begin
        n_bad++;
        $display("FAIL %s per-cycle: act v=%0b w=%h o=%0b exp v=%0b w=%h o=%0b",
                 cur_req, ent_valid, ent_word, overrun, m_valid, m_word, m_ovr);
      end
      if (ent_valid) begin got++; last_word = ent_word; run++; end
      else run = 0;
      if (run > max_run) max_run = run;
      if (overrun) ovr_cnt++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic lvl, input int clocks);
    rx_in = lvl;
    repeat (clocks) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic flip, input logic stop_lvl,
                      input logic tail_lvl, input int tail_bits);
    int   nb;
    logic p;
    nb = 5 + int'(word_len);
    p = 1'b0;
    hold(1'b0, BITCLK);
    for (int i = 0; i < nb; i++) begin
      p = p ^ d[i];
      hold(d[i], BITCLK);
    end
    if (par_en) hold((par_even ? p : ~p) ^ flip, BITCLK);
    hold(stop_lvl, BITCLK);
    hold(tail_lvl, tail_bits * BITCLK);
  endtask

  initial begin
    int g0, o0;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk("R1 valid", int'(ent_valid), 0);
    chk("R1 overrun", int'(overrun), 0);
    chk("R1 word", int'(ent_word), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", int'(ent_word), 0);
    hold(1'b1, 2 * BITCLK);

    cur_req = "R3";
    send(8'hA5, 1'b0, 1'b1, 1'b1, 2);
    chk("R3 8N1 A5", int'(last_word), 'h0A5);
    send(8'h3C, 1'b0, 1'b1, 1'b1, 2);
    chk("R3 8N1 3C", int'(last_word), 'h03C);

    cur_req = "R5"; par_en = 1'b1; par_even = 1'b1;
    send(8'h3C, 1'b0, 1'b1, 1'b1, 2);
    chk("R5 even ok", int'(last_word), 'h03C);
    send(8'h3C, 1'b1, 1'b1, 1'b1, 2);
    chk("R5 even bad", int'(last_word), 'h13C);
    par_even = 1'b0;
    send(8'h01, 1'b0, 1'b1, 1'b1, 2);
    chk("R5 odd ok", int'(last_word), 'h001);
    send(8'h07, 1'b1, 1'b1, 1'b1, 2);
    chk("R5 odd bad", int'(last_word), 'h107);
    par_en = 1'b0;

    cur_req = "R4"; word_len = 2'd0;
    send(8'hFF, 1'b0, 1'b1, 1'b1, 2);
    chk("R4 5 bits", int'(last_word), 'h01F);
    word_len = 2'd2;
    send(8'hFF, 1'b0, 1'b1, 1'b1, 2);
    chk("R4 7 bits", int'(last_word), 'h07F);
    word_len = 2'd3;

    cur_req = "R6";
    send(8'h55, 1'b0, 1'b0, 1'b1, 2);
    chk("R6 framing", int'(last_word), 'h255);

    cur_req = "R2"; g0 = got;
    hold(1'b0, 4 * TDIV);
    hold(1'b1, 3 * BITCLK);
    chk("R2 glitch ignored", got, g0);
    send(8'h5A, 1'b0, 1'b1, 1'b1, 2);
    chk("R2 start after glitch", int'(last_word), 'h05A);

    cur_req = "R7"; par_en = 1'b1; par_even = 1'b0; g0 = got;
    hold(1'b0, 20 * BITCLK);
    chk("R7 one break entry", got, g0 + 1);
    chk("R7 break word", int'(last_word), 'h600);
    hold(1'b1, 2 * BITCLK);
    par_en = 1'b0;
    send(8'h81, 1'b0, 1'b1, 1'b1, 2);
    chk("R7 resume after break", int'(last_word), 'h081);

    cur_req = "R11"; g0 = got;
    send(8'h0F, 1'b0, 1'b0, 1'b0, 30);
    chk("R11 one entry while low", got, g0 + 1);
    chk("R11 framing word", int'(last_word), 'h20F);
    hold(1'b1, 2 * BITCLK);
    send(8'h42, 1'b0, 1'b1, 1'b1, 2);
    chk("R11 next char", int'(last_word), 'h042);

    cur_req = "R9"; sink_full = 1'b1; queue_mode = 1'b0; g0 = got; o0 = ovr_cnt;
    send(8'h11, 1'b0, 1'b1, 1'b1, 2);
    chk("R9 delivered", got, g0 + 1);
    chk("R9 overrun", ovr_cnt, o0 + 1);
    chk("R9 overwrite", int'(last_word), 'h011);

    cur_req = "R10"; queue_mode = 1'b1; g0 = got; o0 = ovr_cnt;
    send(8'h22, 1'b0, 1'b1, 1'b1, 2);
    chk("R10 dropped", got, g0);
    chk("R10 overrun", ovr_cnt, o0 + 1);
    chk("R10 word kept", int'(ent_word), 'h011);
    sink_full = 1'b0;
    send(8'h33, 1'b0, 1'b1, 1'b1, 2);
    chk("R10 accepted when space", int'(last_word), 'h033);

    cur_req = "R8";
    chk("R8 one-cycle strobe", max_run, 1);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog %s: act=timeout exp=finish", cur_req);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule